// File: doc/BRIEF.md
# Ping-Pong Event Packet Formatter

This block runs on a sensor readout card. It gathers the digitized hits that up to a dozen front-end chips report for one triggered event. It packs each event into a stream of tagged 16-bit words for an off-detector module. A level-1 trigger opens an event. The card header is written first, followed by the beam-crossing count captured in the trigger cycle. After that come one tag word per front-end chip, each followed by zero or more hit words. An end-of-data request closes the event. A fixed all-ones trailer is appended only when the event closed cleanly, so the receiver reads a missing trailer as a conversion error.

There are two word buffers, and their roles alternate. One buffer collects the event being converted while the other streams the previous event out through a valid/ready port. The roles swap once the collecting side has closed its event and the streaming side has run empty. Until that swap, the block reports itself busy and ignores any new trigger.

Top module: `evt_pack_top`

## Requirements
- R1: The first word of every event is the card word: bits 15-12 = 4'b1000, bits 11-8 = the `card_addr` input, bits 7-0 = 0. It is written in the cycle where an accepted `l1_trig` is sampled.
- R2: The second word is the value that `bx_count` held in the cycle where the trigger was sampled. All event inputs are ignored in the cycle that follows the trigger.
- R3: A `chip_start` pulse writes a chip word: bits 15-12 = 4'b1001, bits 11-8 = `chip_addr`, bits 7-0 = `chip_sample`.
- R4: A `hit_valid` pulse writes a hit word: bit 15 = 0, bits 14-8 = `hit_chan`, bits 7-0 = `hit_adc`. A chip may be followed by any number of hit words, including none.
- R5: An `end_req` on a clean event appends the trailer 16'hFFFF and closes the event. No further word of that event appears.
- R6: If `prio_out` is high in the cycle where `end_req` is sampled, the event closes without a trailer.
- R7: One event holds at most DEPTH words (default 512). Words beyond that are dropped. Any event that tried to write past the limit, or that has no room left for the trailer, closes without a trailer. An event that ends with exactly DEPTH-1 words still gets its trailer.
- R8: After reset, `evt_busy` = 0 and `out_valid` = 0. `evt_busy` rises after an accepted trigger and stays high until the closed event is handed to the output side. That hand-over occurs only when the output side is empty. A new event can then be collected while the previous one is still being sent, and events leave in trigger order.
- R9: A word leaves on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold steady.
- R10: `l1_trig` is ignored while `evt_busy` is high. `chip_start`, `hit_valid` and `end_req` are ignored while no event is open. Ignored stimulus writes no word.
- R11: Within an open event, if more than one of these is high in the same cycle, the higher one wins: `end_req` over `chip_start` over `hit_valid`. Only the winning word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| card_addr | input | 4 | Card address placed in the card word |
| l1_trig | input | 1 | Level-1 trigger, opens an event |
| bx_count | input | 16 | Free-running beam-crossing counter |
| chip_start | input | 1 | Starts the section of one front-end chip |
| chip_addr | input | 4 | Front-end chip address |
| chip_sample | input | 8 | Level-1 sample number of that chip |
| hit_valid | input | 1 | One hit is presented |
| hit_chan | input | 7 | Channel address of the hit |
| hit_adc | input | 8 | ADC value of the hit |
| end_req | input | 1 | End-of-data request, closes the event |
| prio_out | input | 1 | Priority-out flag; high at close marks an error |
| out_ready | input | 1 | Downstream can accept a word |
| out_valid | output | 1 | `out_data` holds a word |
| out_data | output | 16 | Packed output word |
| evt_busy | output | 1 | Event open or waiting for hand-over |

## Verification
The bench builds events right up to the buffer limit. One event ends with one slot free, one ends exactly full, and one runs well past the limit. A design with an off-by-one in the fullness test would either drop a legal trailer or emit a trailer after data was lost. A second event is filled while the first is held back by a stalled output. This exposes a swap that overwrites words not yet sent, or a busy flag that clears too early. Stray stimulus is applied outside an event, a trigger is sent mid-event, and three event inputs are raised in the same cycle. A formatter that leaks words or picks the wrong winner then shows an extra or misplaced word in the compared stream.

// File: rtl/evt_pack_pkg.sv
// Package evt_pack_pkg
// Shared field widths, word tags and the fill-side state type of the event
// packet formatter. Assumes the fixed 16-bit tagged word layout.
package evt_pack_pkg;

    localparam int WORD_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int CHAN_W  = 7;
    localparam int ADC_W   = 8;
    localparam int SMPL_W  = 8;

    localparam logic [3:0]        TAG_CARD = 4'b1000;
    localparam logic [3:0]        TAG_CHIP = 4'b1001;
    localparam logic [WORD_W-1:0] TRAILER  = 16'hFFFF;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_BX,
        FS_BODY,
        FS_DONE
    } fill_state_t;

    function automatic logic [WORD_W-1:0] card_word(input logic [ADDR_W-1:0] a);
        return {TAG_CARD, a, 8'h00};
    endfunction

    function automatic logic [WORD_W-1:0] chip_word(input logic [ADDR_W-1:0] a,
                                                   input logic [SMPL_W-1:0] s);
        return {TAG_CHIP, a, s};
    endfunction

    function automatic logic [WORD_W-1:0] hit_word(input logic [CHAN_W-1:0] c,
                                                  input logic [ADC_W-1:0]  v);
        return {1'b0, c, v};
    endfunction

endpackage

// File: rtl/evt_pack_buf.sv
// Module evt_pack_buf
// One event buffer: written from word 0 upward while collecting, read from
// word 0 upward while draining. A write at full is dropped. Clearing resets
// both pointers. Assumes DEPTH is a power of two.
module evt_pack_buf #(
    parameter int DEPTH = 512,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic          full,
    output logic          empty,
    output logic [DW-1:0] rd_data
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] cnt;
    logic [CW-1:0] rdp;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (rdp == cnt);
    assign rd_data = mem[rdp[AW-1:0]];

    // Store an accepted word at the current write position.
    always_ff @(posedge clk) begin
        if (wr_en && !full) mem[cnt[AW-1:0]] <= wr_data;
    end

    // Advance the write count and read pointer; clear on reset or role swap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            rdp <= '0;
        end else begin
            if (wr_en && !full) cnt <= cnt + 1'b1;
            if (rd_en && !empty) rdp <= rdp + 1'b1;
        end
    end

    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt <= CW'(DEPTH)) && (rdp <= cnt)); // R7

endmodule

// File: rtl/evt_pack_fill.sv
// Module evt_pack_fill
// Collect side: turns trigger, chip and hit pulses into tagged words for the
// current fill buffer. It tracks overflow and decides whether the trailer is
// written. Assumes at most one word per cycle and DEPTH >= 4.
module evt_pack_fill
    import evt_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] card_addr,
    input  logic              l1_trig,
    input  logic [15:0]       bx_count,
    input  logic              chip_start,
    input  logic [ADDR_W-1:0] chip_addr,
    input  logic [SMPL_W-1:0] chip_sample,
    input  logic              hit_valid,
    input  logic [CHAN_W-1:0] hit_chan,
    input  logic [ADC_W-1:0]  hit_adc,
    input  logic              end_req,
    input  logic              prio_out,
    input  logic              buf_full,
    input  logic              swap,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              done,
    output logic              busy
);
    fill_state_t state;
    logic [15:0] bx_q;
    logic        ovf_q;
    logic        body_word;

    assign body_word = (state == FS_BODY) && !end_req && (chip_start || hit_valid);
    assign done      = (state == FS_DONE);
    assign busy      = (state != FS_IDLE);

    // Pick the single word written this cycle, by state and input priority.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        unique case (state)
            FS_IDLE: if (l1_trig) begin
                wr_en   = 1'b1;
                wr_data = card_word(card_addr);
            end
            FS_BX: begin
                wr_en   = 1'b1;
                wr_data = bx_q;
            end
            FS_BODY: begin
                if (end_req) begin
                    if (!prio_out && !ovf_q && !buf_full) begin
                        wr_en   = 1'b1;
                        wr_data = TRAILER;
                    end
                end else if (chip_start) begin
                    wr_en   = 1'b1;
                    wr_data = chip_word(chip_addr, chip_sample);
                end else if (hit_valid) begin
                    wr_en   = 1'b1;
                    wr_data = hit_word(hit_chan, hit_adc);
                end
            end
            default: ;
        endcase
    end

    // Step the event state machine and capture the crossing count on trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FS_IDLE;
            bx_q  <= '0;
        end else begin
            unique case (state)
                FS_IDLE: if (l1_trig) begin
                    state <= FS_BX;
                    bx_q  <= bx_count;
                end
                FS_BX:   state <= FS_BODY;
                FS_BODY: if (end_req) state <= FS_DONE;
                FS_DONE: if (swap) state <= FS_IDLE;
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Remember that a word of this event was lost to a full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf_q <= 1'b0;
        else if (state == FS_IDLE && l1_trig) ovf_q <= 1'b0;
        else if (body_word && buf_full)       ovf_q <= 1'b1;
    end

    AST_HEADER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(wr_en) && ($past(wr_data[15:12]) == TAG_CARD))); // R1
    AST_TRAILER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && state == FS_BODY && end_req) |-> (!prio_out && !ovf_q && !buf_full)); // R6

endmodule

// File: rtl/evt_pack_swap.sv
// Module evt_pack_swap
// Role arbiter for the two buffers. It hands the filled buffer to the output
// side only when the fill side has closed its event and the output side is
// idle or empty. Assumes exactly two buffers.
module evt_pack_swap (
    input  logic clk,
    input  logic rst_n,
    input  logic fill_done,
    input  logic drain_empty,
    output logic swap,
    output logic fill_sel,
    output logic drain_active
);
    assign swap = fill_done && (!drain_active || drain_empty);

    // Flip buffer roles on a swap; the output side is live after the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_sel     <= 1'b0;
            drain_active <= 1'b0;
        end else if (swap) begin
            fill_sel     <= ~fill_sel;
            drain_active <= 1'b1;
        end
    end

endmodule

// File: rtl/evt_pack_top.sv
// Module evt_pack_top
// Ping-pong event packet formatter. One buffer collects the open event while
// the other streams the previous event out over a valid/ready port. Assumes
// DEPTH is a power of two and at least 4.
module evt_pack_top
    import evt_pack_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] card_addr,
    input  logic              l1_trig,
    input  logic [15:0]       bx_count,
    input  logic              chip_start,
    input  logic [ADDR_W-1:0] chip_addr,
    input  logic [SMPL_W-1:0] chip_sample,
    input  logic              hit_valid,
    input  logic [CHAN_W-1:0] hit_chan,
    input  logic [ADC_W-1:0]  hit_adc,
    input  logic              end_req,
    input  logic              prio_out,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              evt_busy
);
    localparam int NBUF = 2;

    logic              fill_wr;
    logic [WORD_W-1:0] fill_data;
    logic              fill_done;
    logic              swap;
    logic              fill_sel;
    logic              drain_sel;
    logic              drain_active;
    logic              drain_empty;
    logic              buf_full;
    logic              full_v  [NBUF];
    logic              empty_v [NBUF];
    logic [WORD_W-1:0] rd_v    [NBUF];

    assign drain_sel   = ~fill_sel;
    assign buf_full    = full_v[fill_sel];
    assign drain_empty = empty_v[drain_sel];
    assign out_valid   = drain_active && !drain_empty;
    assign out_data    = rd_v[drain_sel];

    evt_pack_fill u_fill (
        .clk        (clk),
        .rst_n      (rst_n),
        .card_addr  (card_addr),
        .l1_trig    (l1_trig),
        .bx_count   (bx_count),
        .chip_start (chip_start),
        .chip_addr  (chip_addr),
        .chip_sample(chip_sample),
        .hit_valid  (hit_valid),
        .hit_chan   (hit_chan),
        .hit_adc    (hit_adc),
        .end_req    (end_req),
        .prio_out   (prio_out),
        .buf_full   (buf_full),
        .swap       (swap),
        .wr_en      (fill_wr),
        .wr_data    (fill_data),
        .done       (fill_done),
        .busy       (evt_busy)
    );

    evt_pack_swap u_swap (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_done   (fill_done),
        .drain_empty (drain_empty),
        .swap        (swap),
        .fill_sel    (fill_sel),
        .drain_active(drain_active)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        evt_pack_buf #(.DEPTH(DEPTH), .DW(WORD_W)) u_buf (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (swap && (drain_sel == 1'(g))),
            .wr_en  (fill_wr && (fill_sel == 1'(g))),
            .wr_data(fill_data),
            .rd_en  (out_valid && out_ready && (drain_sel == 1'(g))),
            .full   (full_v[g]),
            .empty  (empty_v[g]),
            .rd_data(rd_v[g])
        );
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
    AST_SWAP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(evt_busy) |-> $past(!drain_active || drain_empty)); // R8

endmodule

// File: tb/evt_pack_top_tb.sv
// Directed bench for evt_pack_top. The bench keeps its own queue of expected
// words, built from the requirements, and compares every word that leaves.
module evt_pack_top_tb;
    localparam int CLK_P = 10;
    localparam int DEPTH = 512;
    localparam logic [3:0] CARD = 4'hA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  card_addr = CARD;
    logic        l1_trig = 1'b0;
    logic [15:0] bx_count = 16'h1234;
    logic        chip_start = 1'b0;
    logic [3:0]  chip_addr = '0;
    logic [7:0]  chip_sample = '0;
    logic        hit_valid = 1'b0;
    logic [6:0]  hit_chan = '0;
    logic [7:0]  hit_adc = '0;
    logic        end_req = 1'b0;
    logic        prio_out = 1'b0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [15:0] out_data;
    logic        evt_busy;

    int n_tests = 0;
    int n_fail  = 0;
    int ev_words = 0;
    bit ev_ovf = 0;
    bit finished = 0;
    logic [15:0] exp_q [$];
    string       tag_q [$];

    evt_pack_top #(.DEPTH(DEPTH)) u_dut (.*);

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) bx_count <= bx_count + 16'h0111;

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Compare every transferred word against the expected stream.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", out_data, 16'h0000, "unexpected word");
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(out_data === e, t, out_data, e, "stream word");
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic push(input logic [15:0] w, input string t);
        if (ev_words < DEPTH) begin
            exp_q.push_back(w);
            tag_q.push_back(t);
            ev_words++;
        end else begin
            ev_ovf = 1'b1;
        end
    endtask

    task automatic trig(input bit accepted);
        l1_trig = 1'b1;
        if (accepted) begin
            ev_words = 0;
            ev_ovf = 1'b0;
            push({4'b1000, CARD, 8'h00}, "R1");
            push(bx_count, "R2");
        end
        step();
        l1_trig = 1'b0;
        step();
    endtask

    task automatic chip(input logic [3:0] a, input logic [7:0] s);
        chip_start = 1'b1; chip_addr = a; chip_sample = s;
        push({4'b1001, a, s}, "R3");
        step();
        chip_start = 1'b0;
    endtask

    task automatic hit(input logic [6:0] c, input logic [7:0] v);
        hit_valid = 1'b1; hit_chan = c; hit_adc = v;
        push({1'b0, c, v}, "R4");
        step();
        hit_valid = 1'b0;
    endtask

    task automatic finish_ev(input bit prio, input string t);
        end_req = 1'b1; prio_out = prio;
        if (!prio && !ev_ovf && ev_words < DEPTH) push(16'hFFFF, t);
        step();
        end_req = 1'b0; prio_out = 1'b0;
    endtask

    task automatic wait_drain(input string t);
        out_ready = 1'b1;
        for (int i = 0; i < 3000 && exp_q.size() != 0; i++) step();
        repeat (4) step();
        chk(exp_q.size() == 0, t, 16'(exp_q.size()), 16'h0, "words missing");
        chk(!out_valid, t, {15'h0, out_valid}, 16'h0, "stray word after event");
        chk(!evt_busy, "R8", {15'h0, evt_busy}, 16'h0, "busy after drain");
    endtask

    task automatic t_reset();
        chk(out_valid === 1'b0, "R8", {15'h0, out_valid}, 16'h0, "valid at reset");
        chk(evt_busy === 1'b0, "R8", {15'h0, evt_busy}, 16'h0, "busy at reset");
    endtask

    task automatic t_basic();
        trig(1'b1);
        chk(evt_busy === 1'b1, "R8", {15'h0, evt_busy}, 16'h1, "busy in event");
        chip(4'h3, 8'h2C);
        hit(7'h05, 8'h81);
        hit(7'h7F, 8'hFF);
        hit(7'h00, 8'h00);
        chip(4'hB, 8'h07);
        chip(4'h0, 8'hF0);
        hit(7'h41, 8'h3C);
        finish_ev(1'b0, "R5");
        wait_drain("R5");
    endtask

    task automatic t_prio();
        trig(1'b1);
        chip(4'h1, 8'h11);
        hit(7'h22, 8'h33);
        finish_ev(1'b1, "R6");
        wait_drain("R6");
    endtask

    task automatic t_ignored();
        chip_start = 1'b1; hit_valid = 1'b1; step();
        chip_start = 1'b0; hit_valid = 1'b0; end_req = 1'b1; step();
        end_req = 1'b0;
        repeat (4) step();
        chk(!out_valid, "R10", {15'h0, out_valid}, 16'h0, "word from idle stimulus");
        chk(!evt_busy, "R10", {15'h0, evt_busy}, 16'h0, "busy from idle stimulus");
        trig(1'b1);
        chip(4'h6, 8'h66);
        trig(1'b0);
        hit(7'h12, 8'h34);
        // R11: all three event inputs high together, only the trailer is written
        end_req = 1'b1; chip_start = 1'b1; hit_valid = 1'b1;
        chip_addr = 4'h9; hit_chan = 7'h01; hit_adc = 8'h02;
        push(16'hFFFF, "R11");
        step();
        end_req = 1'b0; chip_start = 1'b0; hit_valid = 1'b0;
        wait_drain("R11");
    endtask

    task automatic t_overflow(input int nhits);
        trig(1'b1);
        chip(4'h2, 8'h5A);
        for (int i = 0; i < nhits; i++) hit(7'(i), 8'(i * 3));
        finish_ev(1'b0, "R7");
        wait_drain("R7");
    endtask

    task automatic t_pingpong();
        logic [15:0] held;
        out_ready = 1'b0;
        trig(1'b1);
        chip(4'h4, 8'h44);
        hit(7'h10, 8'hA0);
        finish_ev(1'b0, "R8");
        repeat (3) step();
        chk(!evt_busy, "R8", {15'h0, evt_busy}, 16'h0, "no hand-over to idle output");
        chk(out_valid === 1'b1, "R9", {15'h0, out_valid}, 16'h1, "valid after hand-over");
        held = out_data;
        repeat (4) step();
        chk(out_valid === 1'b1, "R9", {15'h0, out_valid}, 16'h1, "valid dropped in stall");
        chk(out_data === held, "R9", out_data, held, "data moved in stall");
        trig(1'b1);
        chip(4'h5, 8'h55);
        hit(7'h20, 8'hB0);
        hit(7'h21, 8'hB1);
        finish_ev(1'b0, "R8");
        repeat (3) step();
        chk(evt_busy === 1'b1, "R8", {15'h0, evt_busy}, 16'h1, "swap while output full");
        trig(1'b0);
        wait_drain("R8");
    endtask

    initial begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_basic();
        t_prio();
        t_ignored();
        t_overflow(DEPTH - 4);
        t_overflow(DEPTH - 3);
        t_overflow(DEPTH + 8);
        t_pingpong();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R8 watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule